// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling Conversion Sequencer

This block is the digital controller of a two-channel sampling converter. A falling edge on the active-low start input freezes both track-and-hold stages at once. The pair of inputs chosen by the pair-select pin is then converted, channel A first and channel B second. Each conversion is modelled as a fixed number of clock cycles. At the end of each conversion, the result is taken from a stimulus port.

The busy output covers both conversions. Its falling edge means both results are ready. The end-of-convert flag is high once for each channel, with one low cycle between the two. A low-power mode has its own timing. In that mode, holding the start input low makes the block restart on its own after each acquisition. Power-down stops new conversions but lets the current one finish. Reset aborts a conversion at any point.

Top module: `dual_sar_sequencer`

## Requirements
- R1: While `rst` is high, `busy`, `eoc`, `hold`, `latch_stb` and `data_oe` are 0, and the stored results are cleared to zero.
- R2: Conditions for a start are a falling edge of `start_n`, a completed acquisition, and power-down low. When they hold, `busy`, `hold` and `eoc` are high from the next cycle. `sampled_pair` takes the value of `pair_sel` at that edge and keeps it until the next start, even if `pair_sel` changes.
- R3: `eoc` is high for LA cycles, then low for exactly one cycle, then high for LB cycles. `busy` is high for LA+1+LB cycles in total. In normal mode LA=5 and LB=7. In low-power mode LA=9 and LB=6. The mode is taken from `low_power` at the start edge.
- R4: Channel A is always converted first. `sample_a` is stored at the end of the A conversion and can be read while B is still converting. `sample_b` is stored only at the end of the B conversion.
- R5: `latch_stb` is a single-cycle pulse in the first cycle after `busy` falls.
- R6: `data_out` shows the channel A result when `chan_sel` is 1 and the channel B result when it is 0. `chan_sel` does not change the conversion order.
- R7: A falling edge of `start_n` while `busy` is high is ignored. It neither restarts, aborts nor queues a conversion.
- R8: `busy` stays low for at least the acquisition time: 3 cycles in normal mode, 5 in low-power mode, with the mode taken from `low_power` live. A start edge that arrives earlier is held back. The conversion then begins in the first cycle after acquisition completes.
- R9: In low-power mode, `start_n` held low starts a new conversion as soon as acquisition completes. In normal mode, `start_n` held low causes no new conversion.
- R10: `power_down` high does not stop a conversion in progress. It blocks every new start while high. Edges seen while it is high are dropped.
- R11: `rst` raised during a conversion ends it immediately. `busy` is low at the next clock and no result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset and abort |
| start_n | input | 1 | Active-low convert start; falling edge triggers |
| pair_sel | input | 1 | Chooses which input pair is sampled |
| low_power | input | 1 | 1 selects low-power timing and auto-restart |
| power_down | input | 1 | Blocks new conversions |
| chan_sel | input | 1 | Output channel select (1 = A, 0 = B) |
| sample_a | input | W | Modelled conversion value of channel A |
| sample_b | input | W | Modelled conversion value of channel B |
| busy | output | 1 | High from start until both results are stored |
| eoc | output | 1 | High while a channel converts |
| hold | output | 1 | Track-and-hold control, 1 = hold |
| latch_stb | output | 1 | Pulse when both results have been stored |
| sampled_pair | output | 1 | Pair captured at the hold instant |
| data_oe | output | 1 | Data output enable, low during reset |
| data_out | output | W | Selected channel result |

## Verification
The bench counts the cycles after a start edge driven at a falling clock edge. The edge is seen at the next rising edge, so `busy` and `eoc` are due one cycle later. The A result is visible LA+1 cycles after the start, and `latch_stb` with the B result is due LA+LB+2 cycles after it. Held-back and auto-restarted starts become visible after the acquisition count. Every check samples at the falling clock edge at exactly that cycle count and never at a rising edge. The `eoc` and `busy` pattern is compared cycle by cycle over the whole window.

// File: rtl/dual_sar_sequencer.sv
module dual_sar_sequencer #(
  parameter int W          = 16,
  parameter int CONV_A_NRM = 5,
  parameter int CONV_B_NRM = 7,
  parameter int ACQ_NRM    = 3,
  parameter int CONV_A_LP  = 9,
  parameter int CONV_B_LP  = 6,
  parameter int ACQ_LP     = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_n,
  input  logic         pair_sel,
  input  logic         low_power,
  input  logic         power_down,
  input  logic         chan_sel,
  input  logic [W-1:0] sample_a,
  input  logic [W-1:0] sample_b,
  output logic         busy,
  output logic         eoc,
  output logic         hold,
  output logic         latch_stb,
  output logic         sampled_pair,
  output logic         data_oe,
  output logic [W-1:0] data_out
);
  localparam int M1   = CONV_A_NRM > CONV_B_NRM ? CONV_A_NRM : CONV_B_NRM;
  localparam int M2   = CONV_A_LP > CONV_B_LP ? CONV_A_LP : CONV_B_LP;
  localparam int M3   = ACQ_NRM > ACQ_LP ? ACQ_NRM : ACQ_LP;
  localparam int M12  = M1 > M2 ? M1 : M2;
  localparam int MAXN = M12 > M3 ? M12 : M3;
  localparam int CW   = $clog2(MAXN + 1);

  typedef enum logic [1:0] {S_ACQ, S_CA, S_GAP, S_CB} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          start_q, pend, mode_q;
  logic [W-1:0]  res_a, res_b;

  wire           fall     = start_q & ~start_n;
  wire [CW-1:0]  acq_len  = low_power ? CW'(ACQ_LP) : CW'(ACQ_NRM);
  wire [CW-1:0]  len_a    = mode_q ? CW'(CONV_A_LP) : CW'(CONV_A_NRM);
  wire [CW-1:0]  len_b    = mode_q ? CW'(CONV_B_LP) : CW'(CONV_B_NRM);
  wire           acq_done = (st == S_ACQ) && (cnt >= acq_len);
  wire           trig     = fall | pend | (low_power & ~start_n);
  wire           go       = acq_done & trig & ~power_down;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st           <= S_ACQ;
      cnt          <= CW'(1);
      start_q      <= 1'b1;
      pend         <= 1'b0;
      mode_q       <= 1'b0;
      res_a        <= '0;
      res_b        <= '0;
      sampled_pair <= 1'b0;
      latch_stb    <= 1'b0;
    end else begin
      start_q   <= start_n;
      latch_stb <= 1'b0;
      case (st)
        S_ACQ: begin
          if (go) begin
            st           <= S_CA;
            cnt          <= CW'(1);
            mode_q       <= low_power;
            sampled_pair <= pair_sel;
            pend         <= 1'b0;
          end else begin
            if (cnt < acq_len) cnt <= cnt + CW'(1);
            if (power_down) pend <= 1'b0;
            else if (fall) pend <= 1'b1;
          end
        end
        S_CA: begin
          if (cnt == len_a) begin
            res_a <= sample_a;
            st    <= S_GAP;
          end else cnt <= cnt + CW'(1);
        end
        S_GAP: begin
          st  <= S_CB;
          cnt <= CW'(1);
        end
        default: begin
          if (cnt == len_b) begin
            res_b     <= sample_b;
            st        <= S_ACQ;
            cnt       <= CW'(1);
            latch_stb <= 1'b1;
          end else cnt <= cnt + CW'(1);
        end
      endcase
    end
  end

  assign busy     = (st != S_ACQ);
  assign eoc      = (st == S_CA) || (st == S_CB);
  assign hold     = busy;
  assign data_oe  = ~rst;
  assign data_out = rst ? '0 : (chan_sel ? res_a : res_b);

  assert_start_after_acq_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cnt >= acq_len));
  assert_no_start_in_pd_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(power_down));
  assert_start_holds_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (eoc && hold));
  assert_pair_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(sampled_pair));
  assert_gap_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(eoc) && busy) |=> eoc);
  assert_res_a_at_end_a_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_a) |-> $past(st == S_CA));
  assert_res_b_with_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_b) |-> latch_stb);
  assert_strobe_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
    latch_stb |-> (!busy && $past(busy)));
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    latch_stb |=> !latch_stb);
endmodule

// File: tb/sim_dual_sar_sequencer.sv
module sim_dual_sar_sequencer;
  localparam int W = 16;
  localparam int LA_N = 5, LB_N = 7, ACQ_N = 3;
  localparam int LA_L = 9, LB_L = 6, ACQ_L = 5;
  localparam int NV = 6;
  // {low_power, pair_sel, chan_sel, sample_a, sample_b}
  localparam logic [2*W+2:0] VEC [NV] = '{
    {3'b001, 16'h1234, 16'hABCD},
    {3'b010, 16'hFFFF, 16'h0000},
    {3'b101, 16'h0001, 16'h8000},
    {3'b110, 16'h7FFF, 16'h8001},
    {3'b011, 16'h5A5A, 16'hA5A5},
    {3'b100, 16'hC3C3, 16'h3C3C}
  };

  logic clk = 0, rst = 1, start_n = 1, pair_sel = 0, low_power = 0, power_down = 0, chan_sel = 0;
  logic [W-1:0] sample_a = '0, sample_b = '0;
  logic busy, eoc, hold, latch_stb, sampled_pair, data_oe;
  logic [W-1:0] data_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_sar_sequencer #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start_n(start_n), .pair_sel(pair_sel), .low_power(low_power),
    .power_down(power_down), .chan_sel(chan_sel), .sample_a(sample_a), .sample_b(sample_b),
    .busy(busy), .eoc(eoc), .hold(hold), .latch_stb(latch_stb), .sampled_pair(sampled_pair),
    .data_oe(data_oe), .data_out(data_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] prev_b;
    tick(2);
    chk("R1 busy in reset", busy, 0);
    chk("R1 eoc in reset", eoc, 0);
    chk("R1 hold in reset", hold, 0);
    chk("R1 strobe in reset", latch_stb, 0);
    chk("R1 data_oe in reset", data_oe, 0);
    rst = 0;
    prev_b = '0;
    tick(8);

    for (int i = 0; i < NV; i++) begin
      logic lp, pr, cs, seq_ok;
      logic [W-1:0] sa, sb;
      int la, lb, t;
      {lp, pr, cs, sa, sb} = VEC[i];
      la = lp ? LA_L : LA_N;
      lb = lp ? LB_L : LB_N;
      t = la + 1 + lb;
      low_power = lp; pair_sel = pr; chan_sel = cs; sample_a = sa; sample_b = sb;
      tick(8);
      start_n = 0;
      seq_ok = 1;
      for (int k = 1; k <= t + 1; k++) begin
        logic eb, ee;
        tick(1);
        eb = (k <= t);
        ee = (k <= la) || (k >= la + 2 && k <= t);
        if (busy !== eb || eoc !== ee || hold !== eb || latch_stb !== (k == t + 1)) seq_ok = 0;
        if (k == 2) begin start_n = 1; pair_sel = ~pr; end
        if (k == la + 1 && cs) chk("R4 channel A readable during B", data_out, sa);
        if (k == t && !cs) chk("R4 B result not yet stored", data_out, prev_b);
        if (k == t + 1) begin
          chk("R5 strobe after busy falls", latch_stb, 1);
          chk("R6 selected channel output", data_out, cs ? sa : sb);
          chk("R2 pair captured at start", sampled_pair, pr);
        end
      end
      chk("R3 eoc/busy/hold sequence", seq_ok, 1);
      prev_b = sb;
    end

    // R7: edge during busy ignored; R9 normal mode held low gives no restart
    low_power = 0; tick(8);
    start_n = 0; tick(2); start_n = 1; tick(2); start_n = 0;
    tick(10);
    chk("R7 busy at end despite edge", busy, 0);
    chk("R7 strobe at normal end", latch_stb, 1);
    tick(10);
    chk("R7 no queued start", busy, 0);
    chk("R9 normal mode no restart", busy, 0);
    start_n = 1;

    // R8: early start held back until acquisition completes
    tick(8);
    start_n = 0; tick(2); start_n = 1;
    tick(12);
    chk("R8 conversion finished", busy, 0);
    start_n = 0;
    tick(2);
    chk("R8 held back during acquisition", busy, 0);
    tick(1);
    chk("R8 starts when acquisition done", busy, 1);
    start_n = 1; tick(20);

    // R9: low-power auto restart
    low_power = 1; tick(8);
    start_n = 0;
    tick(21);
    chk("R9 low-power acquisition", busy, 0);
    tick(1);
    chk("R9 low-power auto restart", busy, 1);
    start_n = 1; tick(24);
    low_power = 0;

    // R10: power-down
    tick(8);
    start_n = 0; tick(2); start_n = 1; power_down = 1;
    tick(12);
    chk("R10 current conversion completes", latch_stb, 1);
    tick(8);
    start_n = 0; tick(3);
    chk("R10 start blocked", busy, 0);
    tick(10);
    chk("R10 still blocked", busy, 0);
    start_n = 1; power_down = 0; tick(3);
    chk("R10 dropped edge not replayed", busy, 0);
    start_n = 0; tick(1);
    chk("R10 start after release", busy, 1);
    start_n = 1; tick(20);

    // R11: reset aborts
    chan_sel = 1; sample_a = 16'h9999; tick(8);
    start_n = 0; tick(2); start_n = 1; tick(2);
    rst = 1; tick(1);
    chk("R11 busy dropped by reset", busy, 0);
    chk("R11 eoc dropped by reset", eoc, 0);
    chk("R1 data_oe low in reset", data_oe, 0);
    rst = 0; tick(3);
    chk("R11 stays idle", busy, 0);
    chk("R11 no result stored", data_out, 0);
    chk("R1 data_oe after reset", data_oe, 1);
    tick(8);
    start_n = 0; tick(1);
    chk("R2 start after abort", busy, 1);
    start_n = 1; tick(20);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule